// File: doc/BRIEF.md
# Alarm Indication Signal Detector

This block watches the recovered receive bit stream and raises an alarm when the line carries almost nothing but ones. It splits the stream into back-to-back windows of a fixed number of valid bits, counts the zeros in each window, and at the close of every window decides whether the alarm condition is present: too few zeros means alarm. The live condition flag follows that decision window by window.

A sticky status bit sits beside the live flag for the host register file. It is set as soon as the condition is seen. A host read clears it only after the condition has already gone away, so the host always sees at least one read returning 1 for every alarm. A read made while the alarm is still present leaves the bit set. Each cycle with `rx_bit_vld` high carries one bit. Cycles with it low are skipped. `reg_rd` is a one-cycle pulse that marks a host read of the status register.

The status logic is a three-state machine. In S_QUIET the status is 0. In S_ALARM both status and live are 1. In S_AWAIT_RD the status is 1 and live is 0.

The transitions are:
- T_RAISE: S_QUIET to S_ALARM, when a window ends with too few zeros.
- T_RELIEVE: S_ALARM to S_AWAIT_RD, when a window ends with enough zeros.
- T_REARM: S_AWAIT_RD to S_ALARM, when a window ends with too few zeros. This takes precedence over a read in the same cycle.
- T_ACK: S_AWAIT_RD to S_QUIET, on a read.

Top module: `ais_detector`

## Requirements
- R1: After reset, `ais_status` and `ais_live` are 0, and the first window begins with the first valid bit.
- R2: A window is exactly WIN_LEN (default 8192) cycles with `rx_bit_vld`=1, and windows are consecutive and do not overlap. Cycles with `rx_bit_vld`=0 neither advance the window nor count as zeros, whatever `rx_bit` is.
- R3: A zero is a valid bit with `rx_bit`=0, and the window's last bit counts toward that window. After the clock edge that takes in the last bit, `ais_live` is 1 if the window held fewer than ZERO_THR (default 9) zeros and 0 otherwise. `ais_live` changes at no other time.
- R4: `ais_status` becomes 1 on the same edge on which `ais_live` becomes 1.
- R5: A read (`reg_rd`=1) while `ais_live` is 1 leaves `ais_status` at 1.
- R6: A read while `ais_status`=1 and `ais_live`=0 clears `ais_status` on the next edge.
- R7: A read in the same cycle as the last bit of a window that removes the condition does not clear `ais_status`. A later read is needed.
- R8: A window that ends with too few zeros sets both outputs to 1 even if a read arrives in the same cycle.
- R9: `ais_status` never falls without a read in the cycle before it falls, and `ais_live`=1 always implies `ais_status`=1.
- R10: Any window holding ZERO_THR or more zeros, including far more, is treated exactly like one holding ZERO_THR zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Recovered receive data bit |
| rx_bit_vld | input | 1 | Qualifies `rx_bit` for this cycle |
| reg_rd | input | 1 | One-cycle pulse for a host read of the status register |
| ais_status | output | 1 | Sticky alarm status bit |
| ais_live | output | 1 | Condition flag from the last completed window |

## Verification
The bench places zeros at both ends of windows. An off-by-one in window length or in the last-bit handling would therefore credit a zero to the wrong window and flip the threshold decision at exactly 8 or 9 zeros. It fills idle cycles with zeros, which a design that ignored the valid strobe would count as real. It also lands reads in the same cycle as a relieving window end and as a re-arming window end. A design that cleared too early would drop the status unseen, and one that let the read win would miss a fresh alarm. Windows with far more zeros than the threshold expose a zero counter that wraps instead of saturating.

// File: rtl/aisd_pkg.sv
package aisd_pkg;

    typedef enum logic [1:0] {
        S_QUIET    = 2'd0,
        S_ALARM    = 2'd1,
        S_AWAIT_RD = 2'd2
    } aisd_state_e;

endpackage

// File: rtl/aisd_win_ctr.sv
module aisd_win_ctr #(
    parameter int WIN_LEN = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    output logic win_end
);
    localparam int CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [CW-1:0] LAST_POS = CW'(WIN_LEN - 1);

    logic [CW-1:0] pos_q;

    assign win_end = bit_vld && (pos_q == LAST_POS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (bit_vld) begin
            if (pos_q == LAST_POS) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/aisd_zero_ctr.sv
module aisd_zero_ctr #(
    parameter int ZERO_THR = 9,
    localparam int ZW = $clog2(ZERO_THR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_vld,
    input  logic          bit_in,
    input  logic          win_end,
    output logic          win_low,
    output logic [ZW-1:0] zcnt
);
    localparam logic [ZW-1:0] SAT = ZW'(ZERO_THR);

    logic [ZW-1:0] zsum;
    logic          is_zero;

    assign is_zero = bit_vld && !bit_in;

    // Total zeros of the current window including this cycle's bit, saturated.
    always_comb begin
        if (zcnt == SAT) begin
            zsum = SAT;
        end else begin
            zsum = zcnt + ZW'(is_zero);
        end
    end

    assign win_low = win_end && (zsum < SAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zcnt <= '0;
        end else if (bit_vld) begin
            if (win_end) begin
                zcnt <= '0;
            end else begin
                zcnt <= zsum;
            end
        end
    end
endmodule

// File: rtl/aisd_status_fsm.sv
module aisd_status_fsm
    import aisd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        win_end,
    input  logic        win_low,
    input  logic        rd_stb,
    output logic        ais_status,
    output logic        ais_live,
    output aisd_state_e state
);
    aisd_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            S_QUIET: begin
                if (win_end && win_low) state_d = S_ALARM;           // T_RAISE
            end
            S_ALARM: begin
                if (win_end && !win_low) state_d = S_AWAIT_RD;       // T_RELIEVE
            end
            S_AWAIT_RD: begin
                if (win_end && win_low) state_d = S_ALARM;           // T_REARM
                else if (rd_stb)        state_d = S_QUIET;           // T_ACK
            end
            default: state_d = S_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_QUIET;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        ais_status = 1'b0;
        ais_live   = 1'b0;
        unique case (state)
            S_QUIET:    begin ais_status = 1'b0; ais_live = 1'b0; end
            S_ALARM:    begin ais_status = 1'b1; ais_live = 1'b1; end
            S_AWAIT_RD: begin ais_status = 1'b1; ais_live = 1'b0; end
            default:    begin ais_status = 1'b0; ais_live = 1'b0; end
        endcase
    end
endmodule

// File: rtl/ais_detector.sv
module ais_detector
    import aisd_pkg::*;
#(
    parameter int WIN_LEN  = 8192,
    parameter int ZERO_THR = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic rx_bit_vld,
    input  logic reg_rd,
    output logic ais_status,
    output logic ais_live
);
    localparam int ZW = $clog2(ZERO_THR + 1);

    logic          win_end;
    logic          win_low;
    logic [ZW-1:0] zcnt;
    aisd_state_e   fsm_state;

    aisd_win_ctr #(.WIN_LEN(WIN_LEN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (rx_bit_vld),
        .win_end (win_end)
    );

    aisd_zero_ctr #(.ZERO_THR(ZERO_THR)) u_zero (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (rx_bit_vld),
        .bit_in  (rx_bit),
        .win_end (win_end),
        .win_low (win_low),
        .zcnt    (zcnt)
    );

    aisd_status_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_end    (win_end),
        .win_low    (win_low),
        .rd_stb     (reg_rd),
        .ais_status (ais_status),
        .ais_live   (ais_live),
        .state      (fsm_state)
    );
endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk #(
    parameter int ZERO_THR = 9,
    localparam int ZW = $clog2(ZERO_THR + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_rd,
    input logic          ais_status,
    input logic          ais_live,
    input logic          win_end,
    input logic          win_low,
    input logic [ZW-1:0] zcnt
);
    a_r9_live_implies_status: assert property (@(posedge clk) disable iff (!rst_n)
        ais_live |-> ais_status);

    a_r9_no_fall_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ais_status) |-> $past(reg_rd));

    a_r5_read_keeps_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && ais_live) |=> ais_status);

    a_r3_live_only_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(ais_live));

    a_r8_alarm_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && win_low) |=> (ais_live && ais_status));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && ais_status && !ais_live && !win_end) |=> !ais_status);

    a_r10_zero_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        zcnt <= ZW'(ZERO_THR));
endmodule

bind ais_detector ais_detector_chk #(.ZERO_THR(ZERO_THR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .ais_status (ais_status),
    .ais_live   (ais_live),
    .win_end    (win_end),
    .win_low    (win_low),
    .zcnt       (zcnt)
);

// File: tb/ais_detector_tb.sv
module ais_detector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 64;
    localparam int THR = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b1;
    logic rx_bit_vld = 1'b0;
    logic reg_rd = 1'b0;
    logic ais_status;
    logic ais_live;

    int checks = 0;
    int errors = 0;
    int mstate = 0;   // 0 quiet, 1 alarm, 2 awaiting read

    typedef struct {
        logic  st;
        logic  lv;
        string tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ais_detector #(.WIN_LEN(WIN), .ZERO_THR(THR)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .rx_bit_vld (rx_bit_vld),
        .reg_rd     (reg_rd),
        .ais_status (ais_status),
        .ais_live   (ais_live)
    );

    task automatic push(string tag);
        exp_t e;
        e.st  = (mstate != 0);
        e.lv  = (mstate == 1);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic model_step(bit we, bit low, bit rd);
        if (we && low)                         mstate = 1;
        else if (we && mstate == 1)            mstate = 2;
        else if (mstate == 2 && rd)            mstate = 0;
    endtask

    // One full window: nz zeros at its end (or start), gap idle zero cycles between bits.
    task automatic send_window(int nz, bit at_start, int gap, bit rd_last, string tag);
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            rx_bit_vld = 1'b1;
            rx_bit = at_start ? !(i < nz) : !(i >= WIN - nz);
            reg_rd = rd_last && (i == WIN - 1);
            if (gap > 0 && i < WIN - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    rx_bit_vld = 1'b0;
                    rx_bit = 1'b0;
                    reg_rd = 1'b0;
                end
            end
        end
        @(negedge clk);
        rx_bit_vld = 1'b0;
        rx_bit = 1'b1;
        reg_rd = 1'b0;
        model_step(1'b1, nz < THR, rd_last);
        push(tag);
    endtask

    task automatic do_read(string tag);
        @(negedge clk);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        model_step(1'b0, 1'b0, 1'b1);
        push(tag);
    endtask

    // Monitor: compares outputs against queued expectations away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (ais_status !== e.st) begin
                    errors++;
                    $display("FAIL %s ais_status actual %0b expected %0b", e.tag, ais_status, e.st);
                end
                checks++;
                if (ais_live !== e.lv) begin
                    errors++;
                    $display("FAIL %s ais_live actual %0b expected %0b", e.tag, ais_live, e.lv);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push("R1 reset state");
        send_window(0, 0, 0, 0, "R3 R4 all ones raises alarm");
        do_read("R5 read during alarm");
        send_window(THR - 1, 0, 0, 0, "R3 eight zeros stays alarmed");
        send_window(THR, 0, 0, 0, "R3 R2 nine zeros incl last bit relieves");
        do_read("R6 read after relief clears");
        do_read("R6 second read stays clear");
        send_window(THR - 1, 1, 0, 0, "R2 zeros at window start count here");
        send_window(THR, 1, 0, 0, "R2 nine zeros at start relieve");
        do_read("R6 clear again");
        send_window(40, 0, 0, 0, "R10 many zeros stays clear");
        send_window(5, 0, 2, 0, "R2 idle zeros ignored");
        send_window(30, 0, 0, 1, "R7 read at relieving window end");
        do_read("R7 later read clears");
        send_window(0, 0, 0, 0, "R4 alarm again");
        send_window(WIN, 0, 0, 0, "R10 all zeros relieves");
        send_window(3, 0, 0, 1, "R8 alarm beats same cycle read");
        send_window(THR, 0, 0, 0, "R3 relieve");
        send_window(2, 0, 0, 0, "R8 rearm without read");
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule